// File: doc/BRIEF.md
# Quarter-Step Stop UART Transmitter

This block sends data on a single asynchronous serial line. In framed mode it puts a low start bit in front of a character and sends the character least significant bit first. It then holds the line high for a stop interval whose length is set in quarter-bit steps. A stop interval of 1.25 bits is enough for a receiver that joins a continuous stream to find a clean start edge. The settings 1, 1.5, 2 and 3 bits cover the usual conventions.

In raw mode the block adds no framing. It shifts out a caller-supplied word, up to the full word width, with a programmable bit count. Software can use this to build its own framing: nine-bit characters, parity, sync patterns, or several framed characters packed into one write.

Bit timing comes from an enable input that pulses four times per bit period. Whenever the line output is re-enabled, the transmitter holds the line idle for one full ten-bit character time before it sends anything. It signals completion only after the last bit or the whole stop interval has ended.

Top module: `quarter_stop_uart_tx`

## Requirements
- R1: In framed mode a write sends a low start bit, then wrData[7:0] least significant bit first. Each bit lasts 4 tick enables, with no stop bits counted yet. The line goes low on the clock after the write when the idle guard has already finished.
- R2: After the 8th data bit of a framed character, the line stays high for the configured number of ticks. That number is cfgStop, limited to the range 4..12 (4 = 1 bit, 5 = 1.25, 6 = 1.5, 8 = 2, 12 = 3). A value below 4, including 0, acts as 4, and a value above 12 acts as 12.
- R3: done is high for exactly one clock, on the clock where busy falls. That clock comes after the last tick of the stop interval (framed mode) or of the last bit (raw mode), never earlier.
- R4: In raw mode (cfgRaw=1), a write sends the low cfgCount bits of wrData, least significant first, 4 ticks each, with no start or stop bit added. A count of 0, or any count above 32, sends 32 bits. After the last bit the line returns high.
- R5: While txEnable is high, the line stays high until 40 ticks have passed since txEnable rose. Only then can a start bit or a raw bit appear. A write accepted during this guard period is held and sent when the guard ends.
- R6: A write while busy is high is ignored, and the frame in flight is unchanged. It sets overrun, which stays set until a statusRead pulse clears it.
- R7: While txEnable is low, the line is high and writes are ignored. Dropping txEnable during a transfer abandons it: busy falls on the next clock and no done pulse follows.
- R8: Synchronous reset drives the line high and clears busy, done and overrun. It also selects framed mode with a 4-tick stop interval.
- R9: Bit and stop timing advance only on clocks where tick is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Quarter-bit timing enable |
| txEnable | input | 1 | Line output enable; rising edge starts the idle guard |
| cfgWrite | input | 1 | Loads the mode, count and stop settings |
| cfgRaw | input | 1 | 1 = raw unframed mode, 0 = framed |
| cfgCount | input | 6 | Raw-mode bit count (0 means 32) |
| cfgStop | input | 4 | Stop interval in quarter bits |
| wrStrobe | input | 1 | Write request for wrData |
| wrData | input | 32 | Character (bits 7:0) or raw word |
| statusRead | input | 1 | Clears the overrun flag |
| busy | output | 1 | A transfer is pending or in progress |
| done | output | 1 | One-clock completion pulse |
| overrun | output | 1 | Sticky flag for a write rejected while busy |
| serialOut | output | 1 | Serial line, idle high |

## Verification
The bound assertions check every cycle that no low level appears on the line before 40 ticks have passed since enable. They also check that the line is high and busy is clear while output is disabled, that done is a single-clock pulse that coincides with busy falling, and that a write during busy raises overrun. Only the directed scenarios can show the rest, because those properties depend on the data and settings of a whole frame. These are the bit order and values on the line, the exact stop length for each setting including the limited values, the raw bit count and its default of 32, the 4-tick bit spacing under gapped ticks, and the reset defaults.

// File: rtl/quarter_stop_uart_tx_pkg.sv
package quarter_stop_uart_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_DATA,
    ST_STOP
  } txState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture a new word into the shifter
    logic loadRaw;   // 1: word as given, 0: wrap character with start bit
    logic shift;     // advance to the next bit
    logic lineIdle;  // force the line high
  } dpCtl_t;

endpackage

// File: rtl/quarter_stop_uart_tx_dp.sv
module quarter_stop_uart_tx_dp
  import quarter_stop_uart_tx_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtl_t            ctl,
  input  logic [WORD_W-1:0] wrData,
  output logic              serialOut
);

  localparam int PAD_W = WORD_W - CHAR_W - 1;

  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] framedWord;

  // start bit in bit 0, character next, ones above act as idle fill
  assign framedWord = {{PAD_W{1'b1}}, wrData[CHAR_W-1:0], 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '1;
    end else if (ctl.load) begin
      shiftReg <= ctl.loadRaw ? wrData : framedWord;
    end else if (ctl.shift) begin
      shiftReg <= {1'b1, shiftReg[WORD_W-1:1]};
    end
  end

  assign serialOut = ctl.lineIdle | shiftReg[0];

endmodule

// File: rtl/quarter_stop_uart_tx_ctrl.sv
module quarter_stop_uart_tx_ctrl
  import quarter_stop_uart_tx_pkg::*;
#(
  parameter int WORD_W        = 32,
  parameter int CHAR_W        = 8,
  parameter int TICKS_PER_BIT = 4,
  parameter int STOP_W        = 4,
  parameter int STOP_MIN      = 4,
  parameter int STOP_MAX      = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       tick,
  input  logic                       txEnable,
  input  logic                       cfgWrite,
  input  logic                       cfgRaw,
  input  logic [$clog2(WORD_W+1)-1:0] cfgCount,
  input  logic [STOP_W-1:0]          cfgStop,
  input  logic                       wrStrobe,
  input  logic                       statusRead,
  output dpCtl_t                     ctl,
  output logic                       busy,
  output logic                       done,
  output logic                       overrun
);

  localparam int CNT_W   = $clog2(WORD_W + 1);
  localparam int PH_W    = $clog2(TICKS_PER_BIT);
  localparam int GUARD   = TICKS_PER_BIT * (CHAR_W + 2);
  localparam int GUARD_W = $clog2(GUARD + 1);

  txState_t           state;
  logic               cfgRawQ;
  logic [CNT_W-1:0]   cfgBitsQ;
  logic [STOP_W-1:0]  cfgStopQ;
  logic               frmRaw;
  logic [CNT_W-1:0]   bitsLeft;
  logic [STOP_W-1:0]  stopLeft;
  logic [PH_W-1:0]    phase;
  logic [GUARD_W-1:0] guardCnt;
  logic               guardDone;
  logic               lastPhase;
  logic               doneQ;
  logic               overrunQ;

  function automatic logic [STOP_W-1:0] limitStop(input logic [STOP_W-1:0] v);
    if (v < STOP_W'(STOP_MIN)) return STOP_W'(STOP_MIN);
    if (v > STOP_W'(STOP_MAX)) return STOP_W'(STOP_MAX);
    return v;
  endfunction

  function automatic logic [CNT_W-1:0] limitCount(input logic [CNT_W-1:0] v);
    if (v == '0 || v > CNT_W'(WORD_W)) return CNT_W'(WORD_W);
    return v;
  endfunction

  assign guardDone = (guardCnt == GUARD_W'(GUARD));
  assign lastPhase = (phase == PH_W'(TICKS_PER_BIT - 1));

  // configuration register
  always_ff @(posedge clk) begin
    if (rst) begin
      cfgRawQ  <= 1'b0;
      cfgBitsQ <= CNT_W'(WORD_W);
      cfgStopQ <= STOP_W'(STOP_MIN);
    end else if (cfgWrite) begin
      cfgRawQ  <= cfgRaw;
      cfgBitsQ <= limitCount(cfgCount);
      cfgStopQ <= limitStop(cfgStop);
    end
  end

  // idle guard: counts ticks since the output was enabled
  always_ff @(posedge clk) begin
    if (rst || !txEnable) begin
      guardCnt <= '0;
    end else if (tick && !guardDone) begin
      guardCnt <= guardCnt + GUARD_W'(1);
    end
  end

  // sticky overrun, a new rejected write wins over a clear
  always_ff @(posedge clk) begin
    if (rst) begin
      overrunQ <= 1'b0;
    end else if (wrStrobe && state != ST_IDLE) begin
      overrunQ <= 1'b1;
    end else if (statusRead) begin
      overrunQ <= 1'b0;
    end
  end

  // sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      frmRaw   <= 1'b0;
      bitsLeft <= '0;
      stopLeft <= '0;
      phase    <= '0;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (!txEnable) begin
        state <= ST_IDLE;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (wrStrobe) begin
              state    <= ST_WAIT;
              frmRaw   <= cfgRawQ;
              bitsLeft <= cfgRawQ ? cfgBitsQ : CNT_W'(CHAR_W + 1);
              stopLeft <= cfgStopQ;
            end
          end
          ST_WAIT: begin
            if (guardDone) begin
              state <= ST_DATA;
              phase <= '0;
            end
          end
          ST_DATA: begin
            if (tick) begin
              if (lastPhase) begin
                phase <= '0;
                if (bitsLeft == CNT_W'(1)) begin
                  if (frmRaw) begin
                    state <= ST_IDLE;
                    doneQ <= 1'b1;
                  end else begin
                    state <= ST_STOP;
                  end
                end else begin
                  bitsLeft <= bitsLeft - CNT_W'(1);
                end
              end else begin
                phase <= phase + PH_W'(1);
              end
            end
          end
          ST_STOP: begin
            if (tick) begin
              if (stopLeft == STOP_W'(1)) begin
                state <= ST_IDLE;
                doneQ <= 1'b1;
              end else begin
                stopLeft <= stopLeft - STOP_W'(1);
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    ctl.load     = (state == ST_IDLE) && txEnable && wrStrobe;
    ctl.loadRaw  = cfgRawQ;
    ctl.shift    = (state == ST_DATA) && tick && lastPhase;
    ctl.lineIdle = !txEnable || (state != ST_DATA);
  end

  assign busy    = (state != ST_IDLE);
  assign done    = doneQ;
  assign overrun = overrunQ;

endmodule

// File: rtl/quarter_stop_uart_tx.sv
module quarter_stop_uart_tx
  import quarter_stop_uart_tx_pkg::*;
#(
  parameter int WORD_W        = 32,
  parameter int CHAR_W        = 8,
  parameter int TICKS_PER_BIT = 4,
  parameter int STOP_W        = 4,
  parameter int STOP_MIN      = 4,
  parameter int STOP_MAX      = 12
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        tick,
  input  logic                        txEnable,
  input  logic                        cfgWrite,
  input  logic                        cfgRaw,
  input  logic [$clog2(WORD_W+1)-1:0] cfgCount,
  input  logic [STOP_W-1:0]           cfgStop,
  input  logic                        wrStrobe,
  input  logic [WORD_W-1:0]           wrData,
  input  logic                        statusRead,
  output logic                        busy,
  output logic                        done,
  output logic                        overrun,
  output logic                        serialOut
);

  localparam int FRAME_BITS = CHAR_W + 2;

  dpCtl_t ctl;

  quarter_stop_uart_tx_ctrl #(
    .WORD_W(WORD_W), .CHAR_W(CHAR_W), .TICKS_PER_BIT(TICKS_PER_BIT),
    .STOP_W(STOP_W), .STOP_MIN(STOP_MIN), .STOP_MAX(STOP_MAX)
  ) u_ctrl (
    .clk(clk), .rst(rst), .tick(tick), .txEnable(txEnable),
    .cfgWrite(cfgWrite), .cfgRaw(cfgRaw), .cfgCount(cfgCount), .cfgStop(cfgStop),
    .wrStrobe(wrStrobe), .statusRead(statusRead),
    .ctl(ctl), .busy(busy), .done(done), .overrun(overrun)
  );

  quarter_stop_uart_tx_dp #(
    .WORD_W(WORD_W), .CHAR_W(CHAR_W)
  ) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .wrData(wrData), .serialOut(serialOut)
  );

endmodule

// File: rtl/quarter_stop_uart_tx_chk.sv
module quarter_stop_uart_tx_chk #(
  parameter int TICKS_PER_BIT = 4,
  parameter int FRAME_BITS    = 10
) (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic txEnable,
  input logic wrStrobe,
  input logic busy,
  input logic done,
  input logic overrun,
  input logic serialOut
);

  localparam int GUARD   = TICKS_PER_BIT * FRAME_BITS;
  localparam int GUARD_W = $clog2(GUARD + 1);

  // independent count of ticks since enable, saturating
  logic [GUARD_W-1:0] seenTicks;
  always_ff @(posedge clk) begin
    if (rst || !txEnable) seenTicks <= '0;
    else if (tick && seenTicks != GUARD_W'(GUARD)) seenTicks <= seenTicks + GUARD_W'(1);
  end

  // R5: no low level before the full guard has elapsed
  a_r5_guard_before_start: assert property (@(posedge clk) disable iff (rst)
    !serialOut |-> seenTicks == GUARD_W'(GUARD));

  // R7: disabled output is idle high
  a_r7_idle_when_disabled: assert property (@(posedge clk) disable iff (rst)
    !txEnable |-> serialOut);

  // R7: transfer abandoned one clock after disable
  a_r7_busy_dropped: assert property (@(posedge clk) disable iff (rst)
    (!txEnable && $past(!txEnable)) |-> !busy);

  // R3: completion coincides with busy falling
  a_r3_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R3: single-clock pulse
  a_r3_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6: write while busy flags overrun
  a_r6_overrun_on_busy_write: assert property (@(posedge clk) disable iff (rst)
    (wrStrobe && busy) |=> overrun);

endmodule

bind quarter_stop_uart_tx quarter_stop_uart_tx_chk #(
  .TICKS_PER_BIT(TICKS_PER_BIT),
  .FRAME_BITS(FRAME_BITS)
) u_chk (.*);

// File: tb/test_quarter_stop_uart_tx.sv
`timescale 1ns/1ps
module test_quarter_stop_uart_tx;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b1;
  logic        txEnable = 1'b0;
  logic        cfgWrite = 1'b0;
  logic        cfgRaw = 1'b0;
  logic [5:0]  cfgCount = '0;
  logic [3:0]  cfgStop = '0;
  logic        wrStrobe = 1'b0;
  logic [31:0] wrData = '0;
  logic        statusRead = 1'b0;
  logic        busy, done, overrun, serialOut;

  quarter_stop_uart_tx i_quarter_stop_uart_tx (
    .clk(clk), .rst(rst), .tick(tick), .txEnable(txEnable),
    .cfgWrite(cfgWrite), .cfgRaw(cfgRaw), .cfgCount(cfgCount), .cfgStop(cfgStop),
    .wrStrobe(wrStrobe), .wrData(wrData), .statusRead(statusRead),
    .busy(busy), .done(done), .overrun(overrun), .serialOut(serialOut)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int tickTotal = 0;
  always @(posedge clk) if (tick) tickTotal <= tickTotal + 1;

  logic lineArr [0:255];
  logic doneArr [0:255];
  logic busyArr [0:255];
  logic ovArr   [0:255];

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // records n cycles after a write edge; optionally strobes a second write
  task automatic capture(input int n, input int injectAt, input logic [31:0] injData);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wrStrobe = 1'b0;
      lineArr[i] = serialOut;
      doneArr[i] = done;
      busyArr[i] = busy;
      ovArr[i]   = overrun;
      if (i == injectAt) begin
        wrStrobe = 1'b1;
        wrData   = injData;
      end
    end
  endtask

  function automatic int firstDone(input int n);
    for (int i = 0; i < n; i++) if (doneArr[i]) return i;
    return -1;
  endfunction

  task automatic setCfg(input bit raw, input int cnt, input int stop);
    @(negedge clk);
    cfgWrite = 1'b1;
    cfgRaw   = raw;
    cfgCount = 6'(cnt);
    cfgStop  = 4'(stop);
    @(negedge clk);
    cfgWrite = 1'b0;
  endtask

  task automatic testReset();
    check("R8 line high after reset", serialOut, 1);
    check("R8 busy clear after reset", busy, 0);
    check("R8 done clear after reset", done, 0);
    check("R8 overrun clear after reset", overrun, 0);
  endtask

  // enable and write together, default settings
  task automatic testGuard();
    int allHigh = 1;
    @(negedge clk);
    txEnable = 1'b1;
    wrStrobe = 1'b1;
    wrData   = 32'h5A;
    capture(86, -1, 0);
    for (int i = 0; i < 40; i++) if (!lineArr[i]) allHigh = 0;
    check("R5 line high for 40 ticks", allHigh, 1);
    check("R5 start bit after guard", lineArr[40], 0);
    check("R5 write held during guard", busyArr[0], 1);
    check("R8 default framed stop of 4 ticks", firstDone(86), 80);
  endtask

  task automatic testFramed(input logic [7:0] d, input int stopCfg, input int expStop, input string tag);
    logic [7:0] got;
    int stopHigh = 1;
    int n = 37 + expStop + 4;
    setCfg(0, 0, stopCfg);
    wrStrobe = 1'b1;
    wrData   = {24'h0, d};
    capture(n, -1, 0);
    check("R1 start bit low", lineArr[3], 0);
    for (int k = 0; k < 8; k++) got[k] = lineArr[1 + 4 * (k + 1) + 2];
    check("R1 data LSB first", got, d);
    for (int i = 37; i < 37 + expStop; i++) if (!lineArr[i]) stopHigh = 0;
    check({tag, " stop interval high"}, stopHigh, 1);
    check({tag, " done at end of stop"}, firstDone(n), 37 + expStop);
    check("R3 busy through stop", busyArr[36 + expStop], 1);
    check("R3 done single pulse", doneArr[38 + expStop], 0);
  endtask

  task automatic testRaw(input logic [31:0] word, input int cnt, input int expN, input string tag);
    logic [63:0] got = '0;
    logic [63:0] exp;
    int n = 4 * expN + 4;
    exp = (expN == 32) ? {32'h0, word} : ({32'h0, word} & ((64'd1 << expN) - 1));
    setCfg(1, cnt, 4);
    wrStrobe = 1'b1;
    wrData   = word;
    capture(n, -1, 0);
    for (int k = 0; k < expN; k++) got[k] = lineArr[1 + 4 * k + 2];
    check({tag, " raw bits"}, got, exp);
    check({tag, " raw done after last bit"}, firstDone(n), 1 + 4 * expN);
    check("R4 line idle after raw", lineArr[2 + 4 * expN], 1);
  endtask

  task automatic testOverrun();
    logic [7:0] got;
    setCfg(0, 0, 4);
    wrStrobe = 1'b1;
    wrData   = 32'hC3;
    capture(45, 5, 32'h11);
    check("R6 overrun clear before", ovArr[5], 0);
    check("R6 overrun set by busy write", ovArr[6], 1);
    for (int k = 0; k < 8; k++) got[k] = lineArr[1 + 4 * (k + 1) + 2];
    check("R6 frame unchanged", got, 8'hC3);
    check("R6 done timing unchanged", firstDone(45), 41);
    check("R6 overrun sticky", ovArr[44], 1);
    @(negedge clk);
    statusRead = 1'b1;
    @(negedge clk);
    statusRead = 1'b0;
    check("R6 overrun cleared by read", overrun, 0);
  endtask

  task automatic testDisable();
    int sawActivity = 0;
    setCfg(0, 0, 4);
    wrStrobe = 1'b1;
    wrData   = 32'h00;
    capture(10, -1, 0);
    check("R7 frame in progress", lineArr[9], 0);
    txEnable = 1'b0;
    @(negedge clk);
    check("R7 line high when disabled", serialOut, 1);
    check("R7 busy dropped", busy, 0);
    wrStrobe = 1'b1;
    wrData   = 32'h00;
    @(negedge clk);
    wrStrobe = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (done || busy || !serialOut) sawActivity = 1;
    end
    check("R7 no done, write ignored", sawActivity, 0);
    check("R7 no overrun from disabled write", overrun, 0);
    txEnable = 1'b1;
    repeat (45) @(negedge clk);
  endtask

  task automatic testTickGap();
    int t0 = -1;
    int t1 = -1;
    setCfg(1, 3, 4);
    wrStrobe = 1'b1;
    wrData   = 32'b110;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      wrStrobe = 1'b0;
      if (t0 < 0 && !serialOut) t0 = tickTotal;
      if (done) begin
        t1 = tickTotal;
        break;
      end
      tick = ~tick;
    end
    tick = 1'b1;
    check("R9 12 ticks for 3 raw bits", t1 - t0, 12);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    testReset();
    testGuard();
    testFramed(8'hA5, 4, 4, "R2 stop 1 bit");
    testFramed(8'h3C, 5, 5, "R2 stop 1.25 bits");
    testFramed(8'h81, 6, 6, "R2 stop 1.5 bits");
    testFramed(8'h7E, 8, 8, "R2 stop 2 bits");
    testFramed(8'h01, 12, 12, "R2 stop 3 bits");
    testFramed(8'hFE, 0, 4, "R2 stop zero as 4");
    testFramed(8'h55, 2, 4, "R2 stop low limited");
    testFramed(8'hAA, 15, 12, "R2 stop high limited");
    testRaw(32'h0000_01A7, 9, 9, "R4 nine bits");
    testRaw({2'b11, 1'b1, 8'h43, 1'b0, 1'b1, 8'h42, 1'b0, 1'b1, 8'h41, 1'b0}, 30, 30, "R4 three frames");
    testRaw(32'hDEAD_BEEF, 0, 32, "R4 count zero as 32");
    testOverrun();
    testDisable();
    testTickGap();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule